// File: doc/BRIEF.md
# Remote Register Read Engine

This block lets a local host fetch a run of consecutive registers from a device at the far end of a link. The host talks to a small local register map through a simple register bus. It sets the 7-bit identity of the remote target, a byte count, the first remote address and a link mode. It then sets the start bit. The engine issues one link request per byte, stepping the remote address upward. It stores each returned byte in a 16-entry local read window and, when the last byte lands, raises a completion flag and pulls its active-low interrupt.

Two handshake styles are offered to the host. In stall mode, the bus write that sets the start bit is held off until the whole fetch is done, so the host's next access already sees the data. In poll mode, that write is accepted at once. The host then polls the busy and status bits or waits for the interrupt. Both the register bus and the link are valid/ready style. The host must keep a request presented, unchanged, until `bus_ready` is high at a clock edge. The engine holds `link_req`, `link_dev` and `link_addr` steady until `link_ack` is high at an edge. The remote side may hold `link_ack` low for as long as it likes.

Top module: `remote_read_engine`

Register map: 0x02 status (bit 7 done, bit 6 start-while-busy error); 0x10 to 0x1F read window; 0x20 device ID (bits 6:0); 0x22 count code; 0x24 start address; 0x26 start (write bit 0 = 1 to start; reads bit 0 = busy); 0x28 mode (bits 1:0).

## Requirements
- R1: After reset, `irq_n` is 1, `link_req` is 0, `bus_ready` is 1, and status, mode and all 16 window bytes read as 0.
- R2: Register 0x20 reads back its low 7 bits with bit 7 as 0. Registers 0x22 and 0x24 read back all 8 bits. Register 0x28 reads back bits 1:0 with the upper bits as 0.
- R3: Writing 0x26 with bit 0 = 1 while idle starts a fetch. `link_dev` carries the device ID. `link_addr` starts at the start address and rises by 1 (mod 256) after each accepted byte. Request, device ID and address stay steady until acknowledged.
- R4: A count code c fetches c+1 bytes for c from 0 to 15. Any c of 16 or more fetches 16 bytes.
- R5: Byte k of a fetch is stored at 0x10+k. Window bytes beyond the fetched count keep their earlier values. Host writes to 0x10 to 0x1F are ignored.
- R6: When the last byte is accepted, status bit 7 becomes 1 and `irq_n` is 0 from the next cycle.
- R7: Any write to 0x02, whatever the data, clears status bits 7 and 6, and `irq_n` returns to 1. A completion in the same cycle wins.
- R8: With mode 00, a start write is held with `bus_ready` at 0 until the cycle after the last byte is stored. It is then accepted once, without starting another fetch.
- R9: With any mode other than 00, a start write is accepted in its first cycle, and register 0x26 bit 0 reads 1 until the fetch ends.
- R10: In poll mode, a start write while a fetch is running is ignored: the fetch runs on unchanged and no second fetch follows. It also sets the sticky status bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host request present |
| bus_ready | output | 1 | Request accepted at this edge when high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the presented address |
| link_req | output | 1 | Byte request to remote device |
| link_ack | input | 1 | Remote returns a byte this edge |
| link_dev | output | 7 | Remote device ID |
| link_addr | output | 8 | Remote register address |
| link_data | input | 8 | Returned byte, valid with link_ack |
| irq_n | output | 1 | Completion interrupt, active low |

## Verification
The assertions take three things for granted. The host keeps a stalled start write presented until it is accepted. The remote side raises `link_ack` only while `link_req` is high, with `link_data` valid in that cycle. The mode is not changed while a fetch is running. The bench drives the host bus only through tasks that hold each request until `bus_ready` is seen. Its remote model answers only pending requests, after a set latency of zero to three cycles. It writes the mode register only between fetches, after the previous fetch has been confirmed finished.

// File: rtl/rre_pkg.sv
package rre_pkg;
  localparam logic [7:0] REG_STATUS   = 8'h02;
  localparam logic [7:0] REG_WIN_BASE = 8'h10;
  localparam logic [7:0] REG_DEV      = 8'h20;
  localparam logic [7:0] REG_COUNT    = 8'h22;
  localparam logic [7:0] REG_SADDR    = 8'h24;
  localparam logic [7:0] REG_GO       = 8'h26;
  localparam logic [7:0] REG_MODE     = 8'h28;
  localparam logic [1:0] MODE_STALL   = 2'b00;

  typedef enum logic {SEQ_IDLE, SEQ_FETCH} seq_state_t;
endpackage

// File: rtl/rre_cfg.sv
module rre_cfg
  import rre_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DEV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             fin,
  input  logic             err_set,
  output logic [DEV_W-1:0] dev_id,
  output logic [DW-1:0]    count_code,
  output logic [AW-1:0]    start_addr,
  output logic [1:0]       mode,
  output logic             done,
  output logic             err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_id     <= '0;
      count_code <= '0;
      start_addr <= '0;
      mode       <= MODE_STALL;
    end else if (wr_en) begin
      unique case (wr_addr)
        REG_DEV:   dev_id     <= wr_data[DEV_W-1:0];
        REG_COUNT: count_code <= wr_data;
        REG_SADDR: start_addr <= wr_data[AW-1:0];
        REG_MODE:  mode       <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  // Status: set has priority over the write-to-clear
  wire clr = wr_en && (wr_addr == REG_STATUS);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (fin)      done <= 1'b1;
      else if (clr) done <= 1'b0;
      if (err_set)  err  <= 1'b1;
      else if (clr) err  <= 1'b0;
    end
  end
endmodule

// File: rtl/rre_seq.sv
module rre_seq
  import rre_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEV_W = 7,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [DEV_W-1:0] dev_in,
  input  logic [AW-1:0]    addr_in,
  input  logic [IDX_W-1:0] last_in,
  input  logic             link_ack,
  output logic             busy,
  output logic             link_req,
  output logic [DEV_W-1:0] link_dev,
  output logic [AW-1:0]    link_addr,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_stb,
  output logic             fin
);
  seq_state_t       state_q;
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      link_dev  <= '0;
      link_addr <= '0;
      wr_idx    <= '0;
      last_q    <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (launch) begin
          state_q   <= SEQ_FETCH;
          link_dev  <= dev_in;
          link_addr <= addr_in;
          wr_idx    <= '0;
          last_q    <= last_in;
        end
        SEQ_FETCH: if (link_ack) begin
          if (wr_idx == last_q) begin
            state_q <= SEQ_IDLE;
          end else begin
            wr_idx    <= wr_idx + 1'b1;
            link_addr <= link_addr + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == SEQ_FETCH);
  assign link_req = busy;
  assign wr_stb   = busy && link_ack;
  assign fin      = wr_stb && (wr_idx == last_q);
endmodule

// File: rtl/rre_rdbuf.sv
module rre_rdbuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DEPTH-1:0][DW-1:0] ent_w;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DW-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ent_q <= '0;
      else if (wr_stb && wr_idx == IDX_W'(i))    ent_q <= wr_data;
    end
    assign ent_w[i] = ent_q;
  end

  assign rd_data = ent_w[rd_idx];
endmodule

// File: rtl/remote_read_engine.sv
module remote_read_engine
  import rre_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DEV_W = 7,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  output logic             bus_ready,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             link_req,
  input  logic             link_ack,
  output logic [DEV_W-1:0] link_dev,
  output logic [AW-1:0]    link_addr,
  input  logic [DW-1:0]    link_data,
  output logic             irq_n
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEV_W-1:0] dev_id;
  logic [DW-1:0]    count_code, win_data;
  logic [AW-1:0]    start_addr;
  logic [1:0]       mode;
  logic             done, err, busy, fin, wr_stb, release_q;
  logic [IDX_W-1:0] wr_idx, last_idx;

  wire stretch   = (mode == MODE_STALL);
  wire start_hit = bus_valid && bus_write && (bus_addr == REG_GO) && bus_wdata[0];
  assign bus_ready = !(stretch && start_hit && !release_q);
  wire hs        = bus_valid && bus_ready;
  wire launch    = start_hit && !busy && !release_q;
  wire err_set   = hs && start_hit && busy;

  // Stalled start write is released for one acceptance after completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           release_q <= 1'b0;
    else if (fin && stretch && start_hit) release_q <= 1'b1;
    else if (hs)                          release_q <= 1'b0;
  end

  assign last_idx = (count_code >= DW'(DEPTH - 1)) ? IDX_W'(DEPTH - 1)
                                                   : count_code[IDX_W-1:0];

  rre_cfg #(.AW(AW), .DW(DW), .DEV_W(DEV_W)) u_cfg (
    .clk, .rst_n,
    .wr_en(hs && bus_write), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .fin, .err_set,
    .dev_id, .count_code, .start_addr, .mode, .done, .err
  );

  rre_seq #(.AW(AW), .DEV_W(DEV_W), .IDX_W(IDX_W)) u_seq (
    .clk, .rst_n, .launch,
    .dev_in(dev_id), .addr_in(start_addr), .last_in(last_idx),
    .link_ack, .busy, .link_req, .link_dev, .link_addr,
    .wr_idx, .wr_stb, .fin
  );

  rre_rdbuf #(.DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk, .rst_n, .wr_stb, .wr_idx, .wr_data(link_data),
    .rd_idx(bus_addr[IDX_W-1:0]), .rd_data(win_data)
  );

  wire win_hit = (bus_addr[AW-1:IDX_W] == REG_WIN_BASE[AW-1:IDX_W]);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_STATUS: bus_rdata = DW'({done, err, 6'b0});
      REG_DEV:    bus_rdata = DW'(dev_id);
      REG_COUNT:  bus_rdata = count_code;
      REG_SADDR:  bus_rdata = DW'(start_addr);
      REG_GO:     bus_rdata = DW'(busy);
      REG_MODE:   bus_rdata = DW'(mode);
      default:    if (win_hit) bus_rdata = win_data;
    endcase
  end

  assign irq_n = !done;
endmodule

// File: rtl/remote_read_engine_chk.sv
module remote_read_engine_chk
  import rre_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEV_W = 7,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic             link_req,
  input logic             link_ack,
  input logic [DEV_W-1:0] link_dev,
  input logic [AW-1:0]    link_addr,
  input logic             irq_n,
  input logic             fin,
  input logic             busy,
  input logic             stretch,
  input logic             start_hit,
  input logic             launch,
  input logic             err
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic [CW-1:0] acks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    acks_q <= '0;
    else if (launch)               acks_q <= '0;
    else if (link_req && link_ack) acks_q <= acks_q + 1'b1;
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && !link_ack) |=> (link_req && $stable(link_addr) && $stable(link_dev)));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && link_ack) |=> (!link_req || link_addr == AW'($past(link_addr) + 1'b1)));

  assert_max_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (acks_q <= CW'(DEPTH - 1)));

  assert_irq_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !irq_n);

  assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_write && bus_addr == REG_STATUS && !fin) |=> irq_n);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch && start_hit && busy) |-> !bus_ready);

  assert_poll_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stretch |-> bus_ready);

  assert_busy_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stretch && start_hit && busy) |=> err);
endmodule

bind remote_read_engine remote_read_engine_chk #(.AW(AW), .DEV_W(DEV_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_addr(bus_addr), .link_req(link_req),
  .link_ack(link_ack), .link_dev(link_dev), .link_addr(link_addr),
  .irq_n(irq_n), .fin(fin), .busy(busy), .stretch(stretch),
  .start_hit(start_hit), .launch(launch), .err(err)
);

// File: tb/remote_read_engine_tb.sv
module remote_read_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic       bus_ready;
  logic [7:0] bus_rdata;
  logic       link_req, link_ack = 0;
  logic [6:0] link_dev;
  logic [7:0] link_addr, link_data = 0;
  logic       irq_n;

  int checks = 0, fails = 0;
  int lat = 0, acks = 0, wcnt = 0;
  logic [7:0] shadow [16];

  remote_read_engine u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] remote_val(logic [6:0] d, logic [7:0] a);
    return 8'(a * 3) ^ {d, 1'b1} ^ 8'h5A;
  endfunction

  // Remote model: answers a pending request after lat idle cycles
  always @(negedge clk) begin
    if (!rst_n || !link_req) begin
      link_ack = 0; wcnt = 0;
    end else if (wcnt >= lat) begin
      link_ack = 1; link_data = remote_val(link_dev, link_addr);
      acks = acks + 1; wcnt = 0;
    end else begin
      link_ack = 0; wcnt = wcnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, output int stall);
    stall = 0;
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready && stall < 5000) begin
      stall++; @(negedge clk); #1;
    end
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1; d = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic check_window(input string req);
    logic [7:0] v;
    for (int k = 0; k < 16; k++) begin
      bus_rd(8'(8'h10 + k), v);
      check(v == shadow[k], req, v, shadow[k]);
    end
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    v = 1;
    for (int i = 0; i < 300 && v[0]; i++) bus_rd(8'h26, v);
  endtask

  task automatic run_access(input logic [6:0] dev, input logic [7:0] cnt,
                            input logic [7:0] sa, input logic [1:0] mode, input int l);
    int st, n, base;
    logic [7:0] v;
    lat = l;
    bus_wr(8'h20, {1'b0, dev}, st);
    bus_wr(8'h22, cnt, st);
    bus_wr(8'h24, sa, st);
    bus_wr(8'h28, {6'b0, mode}, st);
    n = (cnt > 15) ? 16 : int'(cnt) + 1;
    base = acks;
    bus_wr(8'h26, 8'h01, st);
    if (mode == 2'b00) begin
      check(st > 0, "R8 stall", st, 1);
      check(acks - base == n, "R8 done before accept", acks - base, n);
      bus_rd(8'h26, v);
      check(v == 8'h00, "R8 idle after release", v, 0);
    end else begin
      check(st == 0, "R9 no stall", st, 0);
      wait_idle();
    end
    check(irq_n == 1'b0, "R6 irq low", irq_n, 0);
    bus_rd(8'h02, v);
    check(v == 8'h80, "R6 status", v, 8'h80);
    check(acks - base == n, "R4 byte count", acks - base, n);
    for (int k = 0; k < n; k++) shadow[k] = remote_val(dev, 8'(sa + k));
    check_window("R3/R5 window");
    bus_wr(8'h02, cnt, st);
    check(irq_n == 1'b1, "R7 irq high", irq_n, 1);
    bus_rd(8'h02, v);
    check(v == 8'h00, "R7 status cleared", v, 0);
  endtask

  initial begin
    int st, base;
    logic [7:0] v;
    for (int k = 0; k < 16; k++) shadow[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    check(link_req == 1'b0, "R1 link_req", link_req, 0);
    check(bus_ready == 1'b1, "R1 bus_ready", bus_ready, 1);
    bus_rd(8'h02, v); check(v == 0, "R1 status", v, 0);
    bus_rd(8'h28, v); check(v == 0, "R1 mode", v, 0);
    check_window("R1 window");

    // R2 readback
    bus_wr(8'h20, 8'hFF, st); bus_rd(8'h20, v); check(v == 8'h7F, "R2 dev", v, 8'h7F);
    bus_wr(8'h22, 8'hA5, st); bus_rd(8'h22, v); check(v == 8'hA5, "R2 count", v, 8'hA5);
    bus_wr(8'h24, 8'h3C, st); bus_rd(8'h24, v); check(v == 8'h3C, "R2 saddr", v, 8'h3C);
    bus_wr(8'h28, 8'hFF, st); bus_rd(8'h28, v); check(v == 8'h03, "R2 mode", v, 8'h03);

    // Sweep every count code 0..17 in both modes, varying latency, device, address
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 18; c++)
        run_access(7'(c * 5 + m), 8'(c), 8'(8'hF4 + c * 7), 2'(m), c % 4);
    run_access(7'h55, 8'hFF, 8'h80, 2'b00, 1);   // R4 clamp at the top code
    run_access(7'h2A, 8'd5, 8'h10, 2'b11, 2);    // R9 other nonzero mode

    // R5: host writes into the window are ignored
    bus_wr(8'h13, 8'hEE, st);
    bus_rd(8'h13, v); check(v == shadow[3], "R5 window write ignored", v, shadow[3]);

    // R10: start while busy in poll mode
    lat = 3;
    bus_wr(8'h20, 8'h11, st); bus_wr(8'h22, 8'h03, st);
    bus_wr(8'h24, 8'h40, st); bus_wr(8'h28, 8'h01, st);
    base = acks;
    bus_wr(8'h26, 8'h01, st);
    bus_wr(8'h26, 8'h01, st);
    check(st == 0, "R10 second start accepted", st, 0);
    bus_rd(8'h26, v); check(v == 8'h01, "R9 busy bit", v, 1);
    wait_idle();
    repeat (10) @(negedge clk);
    bus_rd(8'h02, v); check(v == 8'hC0, "R10 error sticky", v, 8'hC0);
    check(acks - base == 4, "R10 no restart", acks - base, 4);
    for (int k = 0; k < 4; k++) shadow[k] = remote_val(7'h11, 8'(8'h40 + k));
    check_window("R10 window");
    bus_wr(8'h02, 8'h00, st);
    bus_rd(8'h02, v); check(v == 8'h00, "R7 clears error", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule